// File: doc/BRIEF.md
# Coprocessor Handshake Interlock Unit

This unit sits between the instruction sequencer of an integer core and an attached numeric coprocessor. For every instruction the sequencer offers, it decides whether the instruction may issue now. Instructions that work on the coprocessor's register stack, and the explicit wait instruction, are held back while the coprocessor reports that it is busy. The initialise and clear-exception instructions bypass that wait, so that a hung coprocessor can always be recovered. Ordinary integer instructions never see the interlock.

The coprocessor may ask for a memory operand at any time. The unit then opens one memory transfer. The direction and address of that transfer come from the last stack instruction that was allowed to issue. While a transfer is open, the unit tells the bus side to use full 32-bit width. It also flags any attempt to narrow the bus to 16 bits.

Both coprocessor inputs are asynchronous, so each passes through a multi-flop synchronizer. The busy line has one more use: its level during reset chooses whether a power-on self-test is enabled.

Top module: `fpu_interlock`

## Requirements
- R1: With dispatch_valid_i high and class code 1 (stack operation) or 2 (wait), stall_o is high exactly while the synchronized busy is high. A change on busy_i reaches stall_o at the second rising clock edge after it, and not at the first.
- R2: Class code 3 (initialise / clear exception) never stalls, whatever the level of busy.
- R3: Class code 0 (integer) never stalls, and stall_o is low whenever dispatch_valid_i is low.
- R4: selftest_o is the inverse of the synchronized busy level seen in the last reset cycle. After reset ends it holds that value.
- R5: Each issued (non-stalled) class-1 dispatch loads dispatch_dir_i and dispatch_addr_i onto xfer_dir_o and xfer_addr_o. A stalled dispatch or a dispatch of another class leaves them unchanged.
- R6: A rising preq_i raises xfer_start_o at the second clock edge after it, as long as no transfer is open. The next edge opens the transfer: force32_o rises and xfer_start_o drops.
- R7: While a transfer is open, no further xfer_start_o is raised. xfer_done_i closes the transfer at the next edge.
- R8: size16_i high during an open transfer raises size_err_o on the next cycle. size16_i outside a transfer leaves size_err_o low.
- R9: During reset, stall_o, xfer_start_o, force32_o and size_err_o are low, and xfer_dir_o and xfer_addr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dispatch_valid_i | input | 1 | Sequencer offers an instruction |
| dispatch_class_i | input | 2 | 0 integer, 1 stack op, 2 wait, 3 init/clear |
| dispatch_dir_i | input | 1 | Operand direction of the offered stack op (1 = write memory) |
| dispatch_addr_i | input | ADDR_W | Operand address of the offered stack op |
| busy_i | input | 1 | Coprocessor busy, asynchronous |
| preq_i | input | 1 | Coprocessor operand request, asynchronous, level |
| xfer_done_i | input | 1 | Memory side finished the open transfer |
| size16_i | input | 1 | Dynamic 16-bit bus-size request |
| stall_o | output | 1 | Hold the offered instruction |
| xfer_start_o | output | 1 | Begin an operand transfer |
| xfer_dir_o | output | 1 | Direction of the operand transfer |
| xfer_addr_o | output | ADDR_W | Address of the operand transfer |
| force32_o | output | 1 | Transfer open; bus must run at 32 bits |
| size_err_o | output | 1 | 16-bit sizing was seen during a transfer |
| selftest_o | output | 1 | Self-test chosen at reset |

## Verification
The hardest case to reach from the ports is a stalled stack dispatch that must leave the stored operand untouched. It needs busy to be synchronized high while a class-1 dispatch carrying a new address is offered. The bench first issues one stack operation with busy low. It then raises busy and waits out the synchronizer. Next it offers a second stack operation with a different address. Finally it fires an operand request and checks that the transfer carries the first address. The self-test choice gets a second reset with the opposite busy level, so that both outcomes are seen.

// File: rtl/fpu_interlock_pkg.sv
package fpu_interlock_pkg;
   typedef enum logic [1:0] {
      CLS_INT   = 2'd0,
      CLS_STACK = 2'd1,
      CLS_WAIT  = 2'd2,
      CLS_INIT  = 2'd3
   } insn_cls_e;
endpackage

// File: rtl/fpu_sync.sv
module fpu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("fpu_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fpu_issue_gate.sv
module fpu_issue_gate
   import fpu_interlock_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  insn_cls_e         cls_i,
   input  logic              dir_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              busy_s_i,
   output logic              stall_o,
   output logic              op_dir_o,
   output logic [ADDR_W-1:0] op_addr_o
);
   logic needs_idle;
   logic issue_stack;

   always_comb begin
      unique case (cls_i)
         CLS_STACK, CLS_WAIT: needs_idle = 1'b1;
         default:             needs_idle = 1'b0;
      endcase
   end

   assign stall_o     = !rst && valid_i && needs_idle && busy_s_i;
   assign issue_stack = valid_i && (cls_i == CLS_STACK) && !stall_o;

   always_ff @(posedge clk) begin
      if (rst) begin
         op_dir_o  <= 1'b0;
         op_addr_o <= '0;
      end else if (issue_stack) begin
         op_dir_o  <= dir_i;
         op_addr_o <= addr_i;
      end
   end

   // R1: a stall is only ever raised on a synchronized busy
   a_r1_stall_needs_busy: assert property (@(posedge clk) disable iff (rst)
      stall_o |-> busy_s_i);
   // R2: init/clear-exception is exempt from the busy wait
   a_r2_init_bypass: assert property (@(posedge clk) disable iff (rst)
      (valid_i && cls_i == CLS_INIT) |-> !stall_o);
   // R5: a stalled dispatch must not disturb the stored operand
   a_r5_stalled_keeps_op: assert property (@(posedge clk) disable iff (rst)
      stall_o |=> $stable(op_addr_o));
endmodule

// File: rtl/fpu_xfer_ctl.sv
module fpu_xfer_ctl (
   input  logic clk,
   input  logic rst,
   input  logic preq_s_i,
   input  logic done_i,
   input  logic size16_i,
   output logic start_o,
   output logic force32_o,
   output logic size_err_o
);
   logic open_q;
   logic err_q;

   assign start_o   = !rst && preq_s_i && !open_q;
   assign force32_o = open_q;
   assign size_err_o = err_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (start_o)     open_q <= 1'b1;
         else if (done_i) open_q <= 1'b0;
         err_q <= open_q && size16_i;
      end
   end

   // R6: a start always opens a transfer on the next cycle
   a_r6_start_opens: assert property (@(posedge clk) disable iff (rst)
      start_o |=> force32_o);
   // R7: no second start while a transfer is open
   a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
      force32_o |-> !start_o);
   // R8: 16-bit sizing inside a transfer is flagged one cycle later
   a_r8_size_flag: assert property (@(posedge clk) disable iff (rst)
      (force32_o && size16_i) |=> size_err_o);
endmodule

// File: rtl/fpu_selftest_latch.sv
module fpu_selftest_latch (
   input  logic clk,
   input  logic rst,
   input  logic busy_s_i,
   output logic selftest_o
);
   logic run_q;
   logic st_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= !busy_s_i;
         run_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
      end
   end

   assign selftest_o = st_q;

   // R4: after reset the self-test choice never moves
   a_r4_selftest_held: assert property (@(posedge clk) disable iff (rst)
      run_q |=> $stable(selftest_o));
endmodule

// File: rtl/fpu_interlock.sv
module fpu_interlock
   import fpu_interlock_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dispatch_valid_i,
   input  logic [1:0]        dispatch_class_i,
   input  logic              dispatch_dir_i,
   input  logic [ADDR_W-1:0] dispatch_addr_i,
   input  logic              busy_i,
   input  logic              preq_i,
   input  logic              xfer_done_i,
   input  logic              size16_i,
   output logic              stall_o,
   output logic              xfer_start_o,
   output logic              xfer_dir_o,
   output logic [ADDR_W-1:0] xfer_addr_o,
   output logic              force32_o,
   output logic              size_err_o,
   output logic              selftest_o
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("fpu_interlock: ADDR_W must be positive");
      end
   endgenerate

   logic busy_s;
   logic preq_s;

   fpu_sync #(.STAGES(SYNC_STAGES)) i_busy_sync (
      .clk (clk), .d_i(busy_i), .q_o(busy_s));

   fpu_sync #(.STAGES(SYNC_STAGES)) i_preq_sync (
      .clk (clk), .d_i(preq_i), .q_o(preq_s));

   fpu_issue_gate #(.ADDR_W(ADDR_W)) i_gate (
      .clk      (clk),
      .rst      (rst),
      .valid_i  (dispatch_valid_i),
      .cls_i    (insn_cls_e'(dispatch_class_i)),
      .dir_i    (dispatch_dir_i),
      .addr_i   (dispatch_addr_i),
      .busy_s_i (busy_s),
      .stall_o  (stall_o),
      .op_dir_o (xfer_dir_o),
      .op_addr_o(xfer_addr_o)
   );

   fpu_xfer_ctl i_xfer (
      .clk       (clk),
      .rst       (rst),
      .preq_s_i  (preq_s),
      .done_i    (xfer_done_i),
      .size16_i  (size16_i),
      .start_o   (xfer_start_o),
      .force32_o (force32_o),
      .size_err_o(size_err_o)
   );

   fpu_selftest_latch i_st (
      .clk       (clk),
      .rst       (rst),
      .busy_s_i  (busy_s),
      .selftest_o(selftest_o)
   );

   // R3: integer instructions and idle slots never stall
   a_r3_no_int_stall: assert property (@(posedge clk) disable iff (rst)
      (!dispatch_valid_i || dispatch_class_i == 2'd0) |-> !stall_o);
endmodule

// File: tb/test_fpu_interlock.sv
module test_fpu_interlock;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dv = 1'b0;
   logic [1:0]    dcls = 2'd0;
   logic          ddir = 1'b0;
   logic [AW-1:0] daddr = '0;
   logic          busy = 1'b1;
   logic          preq = 1'b0;
   logic          done = 1'b0;
   logic          s16 = 1'b0;
   logic          stall, xstart, xdir, f32, serr, st;
   logic [AW-1:0] xaddr;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   fpu_interlock i_fpu_interlock (
      .clk(clk), .rst(rst),
      .dispatch_valid_i(dv), .dispatch_class_i(dcls),
      .dispatch_dir_i(ddir), .dispatch_addr_i(daddr),
      .busy_i(busy), .preq_i(preq), .xfer_done_i(done), .size16_i(s16),
      .stall_o(stall), .xfer_start_o(xstart), .xfer_dir_o(xdir),
      .xfer_addr_o(xaddr), .force32_o(f32), .size_err_o(serr),
      .selftest_o(st));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // {busy, valid, class[1:0], expected stall}
   localparam logic [4:0] VEC [8] = '{
      {1'b1, 1'b1, 2'd1, 1'b1},
      {1'b1, 1'b1, 2'd2, 1'b1},
      {1'b1, 1'b1, 2'd3, 1'b0},
      {1'b1, 1'b1, 2'd0, 1'b0},
      {1'b1, 1'b0, 2'd1, 1'b0},
      {1'b0, 1'b1, 2'd1, 1'b0},
      {1'b0, 1'b1, 2'd2, 1'b0},
      {1'b0, 1'b1, 2'd3, 1'b0}
   };

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // reset with busy high -> no self-test
      repeat (4) @(negedge clk);
      chk("R9 stall in reset", stall, 0);
      chk("R9 start in reset", xstart, 0);
      chk("R9 force32 in reset", f32, 0);
      chk("R9 size_err in reset", serr, 0);
      chk("R9 addr in reset", xaddr, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R4 busy high at reset", st, 0);

      // stall decode table (R1, R2, R3)
      for (int i = 0; i < 8; i++) begin
         busy = VEC[i][4]; dv = VEC[i][3]; dcls = VEC[i][2:1];
         @(posedge clk); @(posedge clk); @(negedge clk);
         chk($sformatf("R1/R2/R3 vector %0d", i), stall, VEC[i][0]);
      end
      dv = 1'b0;
      chk("R4 held after reset", st, 0);

      // two-edge latency of busy to stall (R1)
      busy = 1'b0; dv = 1'b1; dcls = 2'd2;
      repeat (3) @(negedge clk);
      busy = 1'b1;
      @(negedge clk);
      chk("R1 not after one edge", stall, 0);
      @(negedge clk);
      chk("R1 after two edges", stall, 1);
      busy = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R1 released when busy drops", stall, 0);

      // issue a stack op: operand is latched (R5)
      dcls = 2'd1; ddir = 1'b1; daddr = 32'hCAFE_0010;
      @(negedge clk);
      dv = 1'b0;
      chk("R5 addr latched", xaddr, 32'hCAFE_0010);
      chk("R5 dir latched", xdir, 1);
      // non-stack class does not load
      dv = 1'b1; dcls = 2'd3; daddr = 32'h1111_1111; ddir = 1'b0;
      @(negedge clk);
      dv = 1'b0;
      chk("R5 init does not load", xaddr, 32'hCAFE_0010);
      // stalled stack op does not load
      busy = 1'b1;
      @(negedge clk); @(negedge clk);
      dv = 1'b1; dcls = 2'd1; daddr = 32'h2222_2222; ddir = 1'b0;
      @(negedge clk);
      chk("R5 stalled stack op stalls", stall, 1);
      dv = 1'b0;
      chk("R5 stalled op keeps addr", xaddr, 32'hCAFE_0010);
      chk("R5 stalled op keeps dir", xdir, 1);
      busy = 1'b0;

      // size16 outside a transfer (R8)
      s16 = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R8 no flag outside transfer", serr, 0);
      s16 = 1'b0;

      // operand request (R6, R7)
      preq = 1'b1;
      @(negedge clk);
      chk("R6 no start after one edge", xstart, 0);
      @(negedge clk);
      chk("R6 start after two edges", xstart, 1);
      chk("R6 start carries addr", xaddr, 32'hCAFE_0010);
      @(negedge clk);
      chk("R6 force32 opens", f32, 1);
      chk("R7 no restart while open", xstart, 0);
      preq = 1'b0;
      s16 = 1'b1;
      @(negedge clk);
      chk("R8 size16 flagged", serr, 1);
      s16 = 1'b0;
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R7 done closes transfer", f32, 0);
      chk("R7 no start after close", xstart, 0);

      // second reset with busy low -> self-test (R4)
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R4 busy low at reset", st, 1);
      busy = 1'b1;
      repeat (3) @(negedge clk);
      chk("R4 held after busy rises", st, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial busy = 1'b1;
   always @(negedge rst) if (tests > 20) busy = 1'b0;
endmodule